// File: doc/BRIEF.md
# Lookahead-Routing Virtual-Channel Input Port

This block is one input port of a network-on-chip router. It receives flits from a neighbouring router over a single flit link and places each one in a per-virtual-channel FIFO. The channel is taken from the channel field of the packet's head flit. Body and tail flits carry no channel or routing fields of their own, so they follow the channel of the most recent head flit. The link carries one packet at a time.

For every head flit the port works out the output direction the packet will request at the *next* router, which is lookahead routing. It first finds the neighbour that the packet reaches through the output port named in the head flit. It then applies X-then-Y dimension-ordered routing from that neighbour towards the destination. The topology is a 2D mesh or a 2D torus, chosen by parameter. The port stores this precomputed direction with every flit of the packet. Each queue head is offered to the downstream allocators together with its direction.

Back-pressure works in two places. On the incoming link there is no ready signal. The upstream router may send a flit only while it holds a credit for the target channel. The port returns one credit, tagged with the channel number, for every flit it dequeues. On the allocator side, `vc_valid` and `deq_grant` act as valid and ready. A queue head stays on the outputs, unchanged, until it is granted. A grant to an empty channel does nothing.

Top module: `noc_la_input_port`

## Requirements
- R1: A head flit is one whose type field `in_flit[1:0]` is 01 (head) or 11 (single-flit packet). It is written to the channel numbered by `in_flit[11 +: VCW]`. It appears at that channel's `vc_flit` slice, with `vc_valid` set, one clock after the cycle in which `in_valid` accepts it.
- R2: A body flit (type 00) or tail flit (type 10) is written to the channel of the last head flit, whatever its bits [12:2] hold.
- R3: Each channel is a first-in first-out queue of `VC_DEPTH` flits, independent of the other channels. A queue that is not granted does not stall the other queues.
- R4: `vc_route` uses port codes 0=Local, 1=North (y+1), 2=South (y-1), 3=East (x+1) and 4=West (x-1). The head flit carries this hop's port in bits [4:2], destination X in [7:5] and destination Y in [10:8]. The route is computed at the neighbour reached through this hop's port. Any X difference is resolved before Y: East or West first, then North or South.
- R5: With `TORUS`=1, neighbours wrap around at the edges. Each dimension takes the shorter way round, and an exact tie goes to the positive direction (East or North).
- R6: The route is Local when this hop's port is Local, or when the destination equals the neighbour's coordinates.
- R7: Body and tail flits carry the route computed for their packet's head flit.
- R8: A grant on a non-empty channel removes its head flit. One clock later `credit_valid` pulses for one cycle with `credit_vc` set to that channel. A grant on an empty channel produces no credit.
- R9: After reset all channels are empty (`vc_valid`=0) and `credit_valid` is 0.
- R10: A valid queue head that is not granted keeps the same flit, valid and route on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A flit is present on `in_flit` this cycle |
| in_flit | input | FLIT_W | Incoming flit |
| deq_grant | input | NUM_VC | One-hot-or-zero dequeue grant per channel |
| vc_valid | output | NUM_VC | Channel queue is non-empty |
| vc_flit | output | NUM_VC*FLIT_W | Head flit of each channel queue |
| vc_route | output | NUM_VC*3 | Lookahead output port of each queue head |
| credit_valid | output | 1 | One-cycle credit-return pulse |
| credit_vc | output | VCW | Channel the credit belongs to |

## Verification
The bench runs the same flit stream through a mesh instance placed in the interior and a 4x4 torus instance placed on an edge. This shows wraparound and shortest-way choices apart from plain mesh steps. Random multi-flit packets on random channels, mixed with sparse random grants, fill some queues to full depth while others drain. This separates per-channel ordering and independence from a shared queue. Directed head flits cover the torus tie, a Local hop, a destination equal to the neighbour and body flits with junk in the header bits. These show, in turn, the tie rule, the ejection cases and route reuse. Grants to empty channels show that a credit is returned only for a real dequeue.

// File: rtl/noc_la_pkg.sv
package noc_la_pkg;
  typedef enum logic [2:0] {
    PORT_L = 3'd0,
    PORT_N = 3'd1,
    PORT_S = 3'd2,
    PORT_E = 3'd3,
    PORT_W = 3'd4
  } port_e;

  localparam int ROUTE_W  = 3;
  localparam int COORD_W  = 3;
  localparam int TYPE_LSB = 0;
  localparam int PORT_LSB = 2;
  localparam int DSTX_LSB = 5;
  localparam int DSTY_LSB = 8;
  localparam int VC_LSB   = 11;

  // direction along one axis: 0 = none, 1 = positive, 2 = negative
  function automatic logic [1:0] axis_step(input int here, input int dest,
                                           input int size, input bit wrap);
    int fwd;
    if (dest == here) return 2'd0;
    if (!wrap) return (dest > here) ? 2'd1 : 2'd2;
    fwd = (dest - here + size) % size;
    return (2 * fwd <= size) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/noc_la_route.sv
module noc_la_route
  import noc_la_pkg::*;
#(
  parameter int DIM_X  = 5,
  parameter int DIM_Y  = 5,
  parameter int NODE_X = 2,
  parameter int NODE_Y = 2,
  parameter bit TORUS  = 1'b0
) (
  input  logic [2:0]         hop_port,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [2:0]         next_port
);
  always_comb begin
    int hx, hy;
    logic [1:0] sx, sy;
    hx = NODE_X;
    hy = NODE_Y;
    case (hop_port)
      PORT_N:  hy = NODE_Y + 1;
      PORT_S:  hy = NODE_Y - 1;
      PORT_E:  hx = NODE_X + 1;
      PORT_W:  hx = NODE_X - 1;
      default: ;
    endcase
    if (TORUS) begin
      hx = (hx + DIM_X) % DIM_X;
      hy = (hy + DIM_Y) % DIM_Y;
    end
    sx = axis_step(hx, int'(dst_x), DIM_X, TORUS);
    sy = axis_step(hy, int'(dst_y), DIM_Y, TORUS);
    if (hop_port == PORT_L)  next_port = PORT_L;
    else if (sx == 2'd1)     next_port = PORT_E;
    else if (sx == 2'd2)     next_port = PORT_W;
    else if (sy == 2'd1)     next_port = PORT_N;
    else if (sy == 2'd2)     next_port = PORT_S;
    else                     next_port = PORT_L;
  end
endmodule

// File: rtl/noc_la_fifo.sv
module noc_la_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_p];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= bump(wr_p);
      if (do_pop)  rd_p <= bump(rd_p);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/noc_la_input_port.sv
module noc_la_input_port
  import noc_la_pkg::*;
#(
  parameter int NUM_VC   = 3,
  parameter int VC_DEPTH = 4,
  parameter int FLIT_W   = 32,
  parameter int DIM_X    = 5,
  parameter int DIM_Y    = 5,
  parameter int NODE_X   = 2,
  parameter int NODE_Y   = 2,
  parameter bit TORUS    = 1'b0,
  localparam int VCW     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [FLIT_W-1:0]          in_flit,
  input  logic [NUM_VC-1:0]          deq_grant,
  output logic [NUM_VC-1:0]          vc_valid,
  output logic [NUM_VC*FLIT_W-1:0]   vc_flit,
  output logic [NUM_VC*ROUTE_W-1:0]  vc_route,
  output logic                       credit_valid,
  output logic [VCW-1:0]             credit_vc
);
  localparam int ENTRY_W = FLIT_W + ROUTE_W;

  logic                is_head;
  logic [VCW-1:0]      head_vc, pkt_vc, wr_vc;
  logic [ROUTE_W-1:0]  head_route, pkt_route, wr_route;
  logic [NUM_VC-1:0]   q_empty, q_full, q_pop;

  assign is_head = in_flit[TYPE_LSB];
  assign head_vc = in_flit[VC_LSB +: VCW];

  noc_la_route #(
    .DIM_X(DIM_X), .DIM_Y(DIM_Y), .NODE_X(NODE_X), .NODE_Y(NODE_Y), .TORUS(TORUS)
  ) u_route (
    .hop_port (in_flit[PORT_LSB +: 3]),
    .dst_x    (in_flit[DSTX_LSB +: COORD_W]),
    .dst_y    (in_flit[DSTY_LSB +: COORD_W]),
    .next_port(head_route)
  );

  assign wr_vc    = is_head ? head_vc : pkt_vc;
  assign wr_route = is_head ? head_route : pkt_route;

  // packet context for body and tail flits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_vc    <= '0;
      pkt_route <= '0;
    end else if (in_valid && is_head) begin
      pkt_vc    <= head_vc;
      pkt_route <= head_route;
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [ENTRY_W-1:0] q_out;
    assign q_pop[v] = deq_grant[v] && !q_empty[v];

    noc_la_fifo #(.DEPTH(VC_DEPTH), .W(ENTRY_W)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (in_valid && (wr_vc == VCW'(v))),
      .din  ({wr_route, in_flit}),
      .pop  (q_pop[v]),
      .dout (q_out),
      .empty(q_empty[v]),
      .full (q_full[v])
    );

    assign vc_valid[v]                       = !q_empty[v];
    assign vc_flit[v*FLIT_W +: FLIT_W]       = q_out[FLIT_W-1:0];
    assign vc_route[v*ROUTE_W +: ROUTE_W]    = q_out[FLIT_W +: ROUTE_W];
  end

  logic [VCW-1:0] pop_idx;
  always_comb begin
    pop_idx = '0;
    for (int v = NUM_VC - 1; v >= 0; v--) begin
      if (q_pop[v]) pop_idx = VCW'(v);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_valid <= 1'b0;
      credit_vc    <= '0;
    end else begin
      credit_valid <= |q_pop;
      credit_vc    <= pop_idx;
    end
  end
endmodule

// File: rtl/noc_la_input_port_chk.sv
module noc_la_input_port_chk #(
  parameter int NUM_VC = 3,
  parameter int FLIT_W = 32,
  parameter int VCW    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_VC-1:0]        deq_grant,
  input logic [NUM_VC-1:0]        vc_valid,
  input logic [NUM_VC*FLIT_W-1:0] vc_flit,
  input logic [NUM_VC*3-1:0]      vc_route,
  input logic                     credit_valid,
  input logic [VCW-1:0]           credit_vc
);
  logic           live_grant;
  logic [VCW-1:0] grant_idx;

  assign live_grant = |(deq_grant & vc_valid);
  always_comb begin
    grant_idx = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (deq_grant[v] && vc_valid[v]) grant_idx = VCW'(v);
    end
  end

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deq_grant));

  a_r8_credit_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    live_grant |=> credit_valid);

  a_r8_no_idle_credit: assert property (@(posedge clk) disable iff (!rst_n)
    !live_grant |=> !credit_valid);

  a_r8_credit_tag: assert property (@(posedge clk) disable iff (!rst_n)
    live_grant |=> (credit_vc == $past(grant_idx)));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_hold
    a_r10_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_valid[v] && !deq_grant[v]) |=>
        (vc_valid[v] && $stable(vc_flit[v*FLIT_W +: FLIT_W])
                     && $stable(vc_route[v*3 +: 3])));
  end
endmodule

bind noc_la_input_port noc_la_input_port_chk #(
  .NUM_VC(NUM_VC), .FLIT_W(FLIT_W), .VCW(VCW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .deq_grant   (deq_grant),
  .vc_valid    (vc_valid),
  .vc_flit     (vc_flit),
  .vc_route    (vc_route),
  .credit_valid(credit_valid),
  .credit_vc   (credit_vc)
);

// File: tb/noc_la_input_port_tb.sv
`timescale 1ns/1ps
module noc_la_input_port_tb;
  localparam int NV  = 3;
  localparam int DEP = 4;
  localparam int FW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [FW-1:0] in_flit = '0;
  logic [NV-1:0] deq_grant = '0;

  logic [NV-1:0]    m_valid, t_valid;
  logic [NV*FW-1:0] m_flit, t_flit;
  logic [NV*3-1:0]  m_route, t_route;
  logic             m_cv, t_cv;
  logic [1:0]       m_cvc, t_cvc;

  always #10 clk = ~clk;  // 50 MHz

  noc_la_input_port #(.NUM_VC(NV), .VC_DEPTH(DEP), .FLIT_W(FW),
    .DIM_X(5), .DIM_Y(5), .NODE_X(2), .NODE_Y(2), .TORUS(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .deq_grant(deq_grant), .vc_valid(m_valid), .vc_flit(m_flit),
    .vc_route(m_route), .credit_valid(m_cv), .credit_vc(m_cvc));

  noc_la_input_port #(.NUM_VC(NV), .VC_DEPTH(DEP), .FLIT_W(FW),
    .DIM_X(4), .DIM_Y(4), .NODE_X(3), .NODE_Y(0), .TORUS(1'b1)) u_dut_torus (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .deq_grant(deq_grant), .vc_valid(t_valid), .vc_flit(t_flit),
    .vc_route(t_route), .credit_valid(t_cv), .credit_vc(t_cvc));

  int n_chk = 0;
  int n_err = 0;

  logic [FW-1:0] qf [NV][$];
  logic [2:0]    qm [NV][$];
  logic [2:0]    qt [NV][$];
  logic [1:0]    mod_vc = '0;
  logic [2:0]    mod_rm = '0, mod_rt = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // route at the neighbour, from the port rules and coordinate conventions
  function automatic logic [2:0] ref_route(input int cx, input int cy, input logic [2:0] cp,
                                           input int dx, input int dy, input int nx,
                                           input int ny, input bit tor);
    int hx, hy, f;
    hx = cx; hy = cy;
    if (cp == 3'd0) return 3'd0;
    if (cp == 3'd1) hy = cy + 1;
    if (cp == 3'd2) hy = cy - 1;
    if (cp == 3'd3) hx = cx + 1;
    if (cp == 3'd4) hx = cx - 1;
    if (tor) begin hx = (hx + nx) % nx; hy = (hy + ny) % ny; end
    if (dx != hx) begin
      if (tor) begin f = (dx - hx + nx) % nx; return (2 * f <= nx) ? 3'd3 : 3'd4; end
      return (dx > hx) ? 3'd3 : 3'd4;
    end
    if (dy != hy) begin
      if (tor) begin f = (dy - hy + ny) % ny; return (2 * f <= ny) ? 3'd1 : 3'd2; end
      return (dy > hy) ? 3'd1 : 3'd2;
    end
    return 3'd0;
  endfunction

  function automatic logic [31:0] mk_head(input logic [1:0] vc, input logic [2:0] port,
                                          input logic [2:0] dx, input logic [2:0] dy,
                                          input bit single, input logic [18:0] pay);
    return {pay, vc, dy, dx, port, (single ? 2'b11 : 2'b01)};
  endfunction

  task automatic cycle(input logic inv, input logic [FW-1:0] f, input logic [NV-1:0] g);
    logic       ec;
    logic [1:0] ecv;
    in_valid = inv; in_flit = f; deq_grant = g;
    ec = 1'b0; ecv = '0;
    for (int v = 0; v < NV; v++) begin
      if (g[v] && qf[v].size() > 0) begin
        ec = 1'b1; ecv = 2'(v);
        void'(qf[v].pop_front()); void'(qm[v].pop_front()); void'(qt[v].pop_front());
      end
    end
    if (inv) begin
      if (f[0]) begin
        mod_vc = f[12:11];
        mod_rm = ref_route(2, 2, f[4:2], int'(f[7:5]), int'(f[10:8]), 5, 5, 1'b0);
        mod_rt = ref_route(3, 0, f[4:2], int'(f[7:5]), int'(f[10:8]), 4, 4, 1'b1);
      end
      qf[mod_vc].push_back(f); qm[mod_vc].push_back(mod_rm); qt[mod_vc].push_back(mod_rt);
    end
    @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      chk("R3 mesh valid", 64'(m_valid[v]), 64'(qf[v].size() > 0));
      chk("R3 torus valid", 64'(t_valid[v]), 64'(qf[v].size() > 0));
      if (qf[v].size() > 0) begin
        chk("R1 mesh flit", 64'(m_flit[v*FW +: FW]), 64'(qf[v][0]));
        chk("R1 torus flit", 64'(t_flit[v*FW +: FW]), 64'(qf[v][0]));
        chk("R4 mesh route", 64'(m_route[v*3 +: 3]), 64'(qm[v][0]));
        chk("R5 torus route", 64'(t_route[v*3 +: 3]), 64'(qt[v][0]));
      end
    end
    chk("R8 mesh credit", 64'(m_cv), 64'(ec));
    chk("R8 torus credit", 64'(t_cv), 64'(ec));
    if (ec) begin
      chk("R8 mesh credit vc", 64'(m_cvc), 64'(ecv));
      chk("R8 torus credit vc", 64'(t_cvc), 64'(ecv));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int left;
    logic [1:0] pv;
    logic [FW-1:0] f;
    logic [NV-1:0] g;
    logic inv;
    left = 0; pv = '0;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk("R9 reset valid", 64'({m_valid, t_valid}), 64'd0);
    chk("R9 reset credit", 64'({m_cv, t_cv}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'({m_valid, t_valid, m_cv, t_cv}), 64'd0);

    // grant to an empty channel: no credit
    cycle(1'b0, '0, 3'b010);
    chk("R8 empty grant no credit", 64'({m_cv, t_cv}), 64'd0);

    // torus tie: hop East from x=3 wraps to x=0, dest x=2 is 2 either way
    cycle(1'b1, mk_head(2'd0, 3'd3, 3'd2, 3'd0, 1'b1, 19'h1234), '0);
    chk("R5 torus tie goes East", 64'(t_route[2:0]), 64'd3);
    chk("R4 mesh X first West", 64'(m_route[2:0]), 64'd4);
    cycle(1'b0, '0, 3'b001);
    chk("R8 credit pulse vc0", 64'({m_cv, m_cvc}), 64'({1'b1, 2'd0}));
    cycle(1'b0, '0, '0);
    chk("R8 credit one cycle only", 64'({m_cv, t_cv}), 64'd0);

    // Local hop and destination equal to neighbour
    cycle(1'b1, mk_head(2'd1, 3'd0, 3'd1, 3'd1, 1'b1, 19'h0abc), '0);
    chk("R6 local hop mesh", 64'(m_route[5:3]), 64'd0);
    chk("R6 local hop torus", 64'(t_route[5:3]), 64'd0);
    cycle(1'b1, mk_head(2'd2, 3'd1, 3'd3, 3'd1, 1'b1, 19'h00f0), '0);
    chk("R6 torus dest is neighbour", 64'(t_route[8:6]), 64'd0);
    chk("R4 mesh needs East", 64'(m_route[8:6]), 64'd3);

    // multi-flit packet on vc0, body with junk header bits
    cycle(1'b1, mk_head(2'd0, 3'd4, 3'd0, 3'd3, 1'b0, 19'h05555), '0);
    cycle(1'b1, {19'h7ffff, 11'h7ff, 2'b00}, '0);
    cycle(1'b1, {19'h00001, 11'h3a5, 2'b10}, '0);
    chk("R3 vc1 vc2 untouched", 64'(m_valid), 64'b111);
    cycle(1'b0, '0, 3'b001);
    chk("R2 body stays on vc0", 64'(m_flit[31:0]), 64'({19'h7ffff, 11'h7ff, 2'b00}));
    chk("R7 body route mesh", 64'(m_route[2:0]), 64'd4);
    chk("R7 body route torus", 64'(t_route[2:0]), 64'd3);
    cycle(1'b0, '0, 3'b010);
    cycle(1'b0, '0, 3'b100);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      g = '0;
      if ($urandom % 10 < 5) g[$urandom % NV] = 1'b1;
      inv = 1'b0; f = '0;
      if (left == 0) begin
        if ($urandom % 10 < 7) begin
          logic [1:0] nv;
          int len;
          nv = 2'($urandom % NV);
          len = 1 + int'($urandom % 4);
          if (qf[nv].size() < DEP) begin
            f = mk_head(nv, 3'($urandom % 5), 3'($urandom % 4), 3'($urandom % 4),
                        (len == 1), 19'($urandom));
            inv = 1'b1; left = len - 1; pv = nv;
          end
        end
      end else if (qf[pv].size() < DEP) begin
        f = {$urandom} & 32'hffff_fffc;
        f[1:0] = (left == 1) ? 2'b10 : 2'b00;
        inv = 1'b1; left--;
      end
      cycle(inv, f, g);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule